// File: doc/BRIEF.md
# System Reset Control Port

This block is a single byte-wide register at a fixed I/O address that software writes to ask the platform for a reset. Two bits of every write are kept as reset-type flags, one for a full reset and one for a system reset, and they can be read back at the same address. A separate trigger bit in the written byte does not persist. It produces a one-cycle request pulse that the platform's reset sequencer consumes.

Accesses arrive on a small byte bus. The bus carries a port-select strobe, a 16-bit port address, a write enable, write data and combinational read data. Only accesses that carry the strobe and match the port address take effect. The block does not reset anything itself. It raises the request and holds the flags.

Top module: `rstctl_port`

## Requirements
- R1: While reset is asserted, and right after it is released, the stored flags read as 0x00 and the request output is low.
- R2: A write to the port keeps only bit 3 (full-reset flag) and bit 1 (system-reset flag) of the written byte. The stored value is the data ANDed with 0x0A, and it replaces the previous flags.
- R3: A write to the port with bit 2 set drives the request output high for exactly the one clock cycle that follows the write's capturing edge.
- R4: A write to the port with bit 2 clear never raises the request output.
- R5: Bit 2 is never retained. A read after any write returns 0 in bit 2 and in bits 7:4 and bit 0.
- R6: Raising a request does not alter the stored flags. A write of 0x0E reads back as 0x0A after the pulse.
- R7: Accesses whose address differs from 0x0CF9 are ignored: the flags do not change, no request is raised, and read data is 0x00.
- R8: A read at 0x0CF9, with the strobe high and write enable low, returns the stored flags in the same cycle. Read data is 0x00 whenever no such read is presented.
- R9: With the port-select strobe low, a write at 0x0CF9 carrying bit 2 changes nothing and raises no request.
- R10: Writes on consecutive cycles are each acted on. Two back-to-back writes with bit 2 set hold the request output high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 1 | Access strobe, qualifies the address and write enable |
| port_addr | input | 16 | I/O port address of the access |
| wr_en | input | 1 | 1 for a write, 0 for a read |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data, combinational, 0 when no read hits the port |
| rst_req | output | 1 | One-cycle platform reset request |

## Verification
Read data is combinational, so it is due in the same cycle as the read. The bench samples it shortly after the falling edge on which the read is driven, well before the next rising edge. The flag update and the request pulse each pass through one register. Both are sampled at the falling edge after the capturing rising edge, and the request is sampled again one cycle later to confirm that it has dropped. Every write task drives its inputs on a falling edge and releases them on the next one, so no sample lands on an active edge.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    localparam int unsigned DATA_W   = 8;
    localparam int unsigned ADDR_W   = 16;
    localparam int unsigned FULL_BIT = 3;
    localparam int unsigned SYS_BIT  = 1;
    localparam int unsigned TRIG_BIT = 2;

    localparam logic [DATA_W-1:0] KEEP_MASK =
        (DATA_W'(1) << FULL_BIT) | (DATA_W'(1) << SYS_BIT);

    typedef struct packed {
        logic [DATA_W-1:0] flags;
        logic              req;
    } rstctl_state_t;

endpackage

// File: rtl/rstctl_decode.sv
module rstctl_decode #(
    parameter int unsigned             ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]       PORT_ADDR = 16'h0CF9
) (
    input  logic              port_sel,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic              wr_en,
    output logic              wr_hit,
    output logic              rd_hit
);

    logic addr_match;

    always_comb begin
        addr_match = port_sel && (port_addr == PORT_ADDR);
        wr_hit     = addr_match && wr_en;
        rd_hit     = addr_match && !wr_en;
    end

endmodule

// File: rtl/rstctl_regs.sv
module rstctl_regs
    import rstctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] flags_q,
    output logic              req_q
);

    rstctl_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.req = 1'b0;
        if (wr_hit) begin
            state_d.flags = wr_data & KEEP_MASK;
            state_d.req   = wr_data[TRIG_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags_q = state_q.flags;
    assign req_q   = state_q.req;

    AST_REQ_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_data[TRIG_BIT]) |=> req_q); // R3

    AST_REQ_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> $past(wr_hit && wr_data[TRIG_BIT])); // R4

    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(flags_q)); // R7

    AST_FLAGS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (flags_q == ($past(wr_data) & KEEP_MASK))); // R2

endmodule

// File: rtl/rstctl_port.sv
module rstctl_port
    import rstctl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_sel,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rst_req
);

    logic              wr_hit;
    logic              rd_hit;
    logic [DATA_W-1:0] flags_q;

    rstctl_decode #(
        .ADDR_W    (ADDR_W),
        .PORT_ADDR (PORT_ADDR)
    ) u_decode (
        .port_sel  (port_sel),
        .port_addr (port_addr),
        .wr_en     (wr_en),
        .wr_hit    (wr_hit),
        .rd_hit    (rd_hit)
    );

    rstctl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wr_data (wr_data),
        .flags_q (flags_q),
        .req_q   (rst_req)
    );

    always_comb begin
        rd_data = rd_hit ? flags_q : '0;
    end

    AST_TRIG_NOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[TRIG_BIT] == 1'b0); // R5

    AST_NOSEL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !port_sel |=> !rst_req); // R9

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_sel && !wr_en) |-> (rd_data == '0)); // R8

endmodule

// File: tb/rstctl_port_tb.sv
module rstctl_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] PORT = 16'h0CF9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_sel = 1'b0;
    logic [15:0] port_addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstctl_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_sel  (port_sel),
        .port_addr (port_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .rst_req   (rst_req)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // Write on one cycle; returns request level after the edge and one cycle later.
    task automatic do_write(input logic sel, input logic [15:0] addr, input logic [7:0] data,
                            output logic req_now, output logic req_next);
        @(negedge clk);
        port_sel = sel; port_addr = addr; wr_en = 1'b1; wr_data = data;
        @(negedge clk);
        req_now = rst_req;
        port_sel = 1'b0; wr_en = 1'b0; wr_data = '0; port_addr = '0;
        @(negedge clk);
        req_next = rst_req;
    endtask

    task automatic do_read(input logic [15:0] addr, output logic [7:0] val);
        @(negedge clk);
        port_sel = 1'b1; port_addr = addr; wr_en = 1'b0;
        #1;
        val = rd_data;
        @(negedge clk);
        port_sel = 1'b0; port_addr = '0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        #1;
        check({7'd0, rst_req}, 8'h00, "R1 req during reset");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check({7'd0, rst_req}, 8'h00, "R1 req after release");
        do_read(PORT, v);
        check(v, 8'h00, "R1 flags after reset");
    endtask

    task automatic t_mask();
        logic a, b;
        logic [7:0] v;
        do_write(1'b1, PORT, 8'hFB, a, b);
        check({7'd0, a}, 8'h00, "R4 no req without bit2");
        do_read(PORT, v);
        check(v, 8'h0A, "R2 mask 0xFB");
        do_write(1'b1, PORT, 8'h08, a, b);
        do_read(PORT, v);
        check(v, 8'h08, "R2 full flag only");
        do_write(1'b1, PORT, 8'h03, a, b);
        do_read(PORT, v);
        check(v, 8'h02, "R2 sys flag only");
        do_write(1'b1, PORT, 8'h00, a, b);
        do_read(PORT, v);
        check(v, 8'h00, "R2 cleared by write");
    endtask

    task automatic t_trigger();
        logic a, b;
        logic [7:0] v;
        do_write(1'b1, PORT, 8'h06, a, b);
        check({7'd0, a}, 8'h01, "R3 pulse high");
        check({7'd0, b}, 8'h00, "R3 pulse one cycle");
        do_read(PORT, v);
        check(v, 8'h02, "R5 bit2 not kept");
        do_write(1'b1, PORT, 8'h0E, a, b);
        check({7'd0, a}, 8'h01, "R3 pulse with both flags");
        do_read(PORT, v);
        check(v, 8'h0A, "R6 flags survive pulse");
        do_write(1'b1, PORT, 8'hFF, a, b);
        do_read(PORT, v);
        check(v, 8'h0A, "R5 only bits 3 and 1 of 0xFF");
    endtask

    task automatic t_other_addr();
        logic a, b;
        logic [7:0] v;
        do_write(1'b1, PORT, 8'h08, a, b);
        do_write(1'b1, 16'h0CF8, 8'hFF, a, b);
        check({7'd0, a}, 8'h00, "R7 no req other addr");
        do_read(PORT, v);
        check(v, 8'h08, "R7 flags unchanged other addr");
        do_read(16'h0CF9 ^ 16'h1000, v);
        check(v, 8'h00, "R7 read other addr zero");
        do_write(1'b0, PORT, 8'h06, a, b);
        check({7'd0, a}, 8'h00, "R9 no req without strobe");
        do_read(PORT, v);
        check(v, 8'h08, "R9 flags unchanged without strobe");
    endtask

    task automatic t_idle_read();
        @(negedge clk);
        port_sel = 1'b0; port_addr = PORT; wr_en = 1'b0;
        #1;
        check(rd_data, 8'h00, "R8 no strobe read zero");
        port_addr = '0;
    endtask

    task automatic t_back2back();
        logic r1, r2, r3;
        logic [7:0] v;
        @(negedge clk);
        port_sel = 1'b1; port_addr = PORT; wr_en = 1'b1; wr_data = 8'h04;
        @(negedge clk);
        r1 = rst_req;
        wr_data = 8'h06;
        @(negedge clk);
        r2 = rst_req;
        port_sel = 1'b0; wr_en = 1'b0; wr_data = '0; port_addr = '0;
        @(negedge clk);
        r3 = rst_req;
        check({7'd0, r1}, 8'h01, "R10 first pulse");
        check({7'd0, r2}, 8'h01, "R10 second pulse");
        check({7'd0, r3}, 8'h00, "R10 drop after burst");
        do_read(PORT, v);
        check(v, 8'h02, "R10 last write wins");
    endtask

    initial begin
        t_reset();
        t_mask();
        t_trigger();
        t_other_addr();
        t_idle_read();
        t_back2back();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule